// File: doc/BRIEF.md
# Multiplexed LCD Waveform Sequencer

This block turns a small display memory into the drive-level codes for a multiplexed liquid-crystal panel with up to four common lines and thirty-two segment lines. A phase counter steps through the commons in use, holding each for a fixed number of clock cycles. For every phase the block emits a two-bit level code on each common line and each segment line. An analog resistor or capacitor ladder outside the block turns those codes into voltages. Each frame is split into two halves of opposite polarity, so that no pixel sees a net DC voltage.

A host writes the picture through a simple synchronous port: one four-bit word per segment, one bit of the word per common. A three-bit configuration word selects the number of commons (two, three or four) and the bias scheme (half or third). A drive-enable input blanks every line to ground. While the drive is off, the phase counter is parked so that the next frame starts cleanly.

Top module: `lcd_mux_seq`

## Requirements
- R1: The display memory holds 32 words of 4 bits. A write (`host_we`=1) to an address below 32 stores `host_wdata`. A read (`host_re`=1) presents the stored word on `host_rdata` one clock later, and `host_rdata` holds its value while no read is requested.
- R2: For an address whose bit 5 is set (32 to 63), a write leaves the memory unchanged and a read returns 0.
- R3: While common k is the active phase, segment n is at the "on" level if bit k of word n is 1 and at the "off" level otherwise.
- R4: `cfg_word[2:1]` selects the number of commons: 00 gives two, 01 gives three, 10 and 11 give four. `cfg_word[0]`=0 selects half bias and 1 selects third bias.
- R5: With the drive enabled, commons 0 up to N-1 become active in turn, each for `CLK_DIV` clock cycles. After N phases the polarity flips, so a frame lasts 2N phases. At most one common is at a select level (code 0 or 3) at any time.
- R6: Level codes are 0=VSS, 1=one-third, 2=two-thirds, 3=VLCD. Under third bias, in the positive half (first half of the frame) the active common is 3, other commons are 1, "on" segments are 0 and "off" segments are 2. In the negative half these become 0, 2, 3 and 1.
- R7: Under half bias, the active common is 3 in the positive half and 0 in the negative half. Inactive commons are 1. "On" segments are 0 in the positive half and 3 in the negative half. "Off" segments are 3 in the positive half and 0 in the negative half. Code 2 never appears.
- R8: Commons with an index at or beyond the selected count stay at the non-select level (1 or 2 under third bias, 1 under half bias).
- R9: While `drive_en` is 0, every common and segment output is 0 from the next clock on. When `drive_en` is raised, the first phase driven is common 0 in the positive half.
- R10: After reset all level outputs and `host_rdata` are 0, and every memory word reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drive_en | input | 1 | Enables the panel drive; 0 blanks all lines |
| cfg_word | input | 3 | [2:1] common count code, [0] third-bias select |
| host_we | input | 1 | Memory write strobe |
| host_re | input | 1 | Memory read strobe |
| host_addr | input | 6 | Memory address |
| host_wdata | input | 4 | Write data; bit k belongs to common k |
| host_rdata | output | 4 | Registered read data |
| com_lvl | output | 8 | Level code per common, common k at bits [2k+1:2k] |
| seg_lvl | output | 64 | Level code per segment, segment n at bits [2n+1:2n] |

## Verification
The hardest case to reach from the ports is the negative half of a frame under each common count. The polarity flips only after every active common has had its turn, and the block exposes neither the phase nor the polarity. The stimulus therefore starts each run from a parked sequencer by raising `drive_en`. It then steps exactly `CLK_DIV` cycles per phase through two full frames, checking both the first and the last cycle of every phase. Memory patterns are chosen so that each common sees a different mix of on and off segments. The out-of-range address test writes an address that would alias a live word if bit 5 were dropped, and then reads that live word back.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_VSS  = 2'd0;
  localparam lvl_t LVL_1T   = 2'd1;
  localparam lvl_t LVL_2T   = 2'd2;
  localparam lvl_t LVL_VLCD = 2'd3;

  // last active common index from the count code
  function automatic logic [1:0] last_com_of(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd1;
      2'b01:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic lvl_t com_code(input logic run, input logic sel,
                                    input logic used, input logic third,
                                    input logic neg);
    if (!run)        return LVL_VSS;
    if (sel && used) return neg ? LVL_VSS : LVL_VLCD;
    if (third)       return neg ? LVL_2T : LVL_1T;
    return LVL_1T;
  endfunction

  function automatic lvl_t seg_code(input logic run, input logic on,
                                    input logic third, input logic neg);
    if (!run) return LVL_VSS;
    if (on)   return neg ? LVL_VLCD : LVL_VSS;
    if (third) return neg ? LVL_1T : LVL_2T;
    return neg ? LVL_VSS : LVL_VLCD;
  endfunction
endpackage

// File: rtl/lcdw_dispmem.sv
module lcdw_dispmem #(
  parameter int WORDS  = 32,
  parameter int DW     = 4,
  parameter int ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic                  re,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  output logic [WORDS*DW-1:0]   words_flat
);
  localparam int IDX_W = $clog2(WORDS);

  logic [DW-1:0] mem [WORDS];
  logic          in_range;
  logic [IDX_W-1:0] idx;

  assign in_range = (addr < ADDR_W'(WORDS));
  assign idx      = addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we && in_range) begin
      mem[idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             rdata <= '0;
    else if (re)         rdata <= in_range ? mem[idx] : '0;
  end

  for (genvar n = 0; n < WORDS; n++) begin : g_flat
    assign words_flat[n*DW +: DW] = mem[n];
  end
endmodule

// File: rtl/lcdw_sequencer.sv
module lcdw_sequencer #(
  parameter int N_COM   = 4,
  parameter int CLK_DIV = 128
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      run,
  input  logic [$clog2(N_COM)-1:0]  last_com,
  output logic [$clog2(N_COM)-1:0]  cur_com,
  output logic                      neg
);
  localparam int CI_W  = $clog2(N_COM);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] div_cnt;
  logic             step;

  assign step = (div_cnt == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_cnt <= '0;
      cur_com <= '0;
      neg     <= 1'b0;
    end else if (step) begin
      div_cnt <= '0;
      if (cur_com >= last_com) begin
        cur_com <= '0;
        neg     <= ~neg;
      end else begin
        cur_com <= cur_com + CI_W'(1);
      end
    end else begin
      div_cnt <= div_cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/lcdw_level_map.sv
module lcdw_level_map
  import lcdw_pkg::*;
#(
  parameter int N_SEG = 32,
  parameter int N_COM = 4
) (
  input  logic                          run,
  input  logic                          third,
  input  logic                          neg,
  input  logic [$clog2(N_COM)-1:0]      cur_com,
  input  logic [$clog2(N_COM)-1:0]      last_com,
  input  logic [N_SEG*N_COM-1:0]        words_flat,
  output logic [N_COM*LVL_W-1:0]        com_d,
  output logic [N_SEG*LVL_W-1:0]        seg_d
);
  localparam int CI_W = $clog2(N_COM);

  for (genvar k = 0; k < N_COM; k++) begin : g_com
    logic sel, used;
    assign sel  = (cur_com == CI_W'(k));
    assign used = (CI_W'(k) <= last_com);
    assign com_d[k*LVL_W +: LVL_W] = com_code(run, sel, used, third, neg);
  end

  for (genvar n = 0; n < N_SEG; n++) begin : g_seg
    logic [N_COM-1:0] word;
    assign word = words_flat[n*N_COM +: N_COM];
    assign seg_d[n*LVL_W +: LVL_W] = seg_code(run, word[cur_com], third, neg);
  end
endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
  import lcdw_pkg::*;
#(
  parameter int N_SEG   = 32,
  parameter int N_COM   = 4,
  parameter int ADDR_W  = 6,
  parameter int CLK_DIV = 128
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     drive_en,
  input  logic [2:0]               cfg_word,
  input  logic                     host_we,
  input  logic                     host_re,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [N_COM-1:0]         host_wdata,
  output logic [N_COM-1:0]         host_rdata,
  output logic [N_COM*LVL_W-1:0]   com_lvl,
  output logic [N_SEG*LVL_W-1:0]   seg_lvl
);
  localparam int CI_W = $clog2(N_COM);

  logic [N_SEG*N_COM-1:0]   words_flat;
  logic [CI_W-1:0]          last_com, cur_com;
  logic                     neg;
  logic [N_COM*LVL_W-1:0]   com_d;
  logic [N_SEG*LVL_W-1:0]   seg_d;

  assign last_com = CI_W'(last_com_of(cfg_word[2:1]));

  lcdw_dispmem #(.WORDS(N_SEG), .DW(N_COM), .ADDR_W(ADDR_W)) mem_i (
    .clk(clk), .rst(rst), .we(host_we), .re(host_re), .addr(host_addr),
    .wdata(host_wdata), .rdata(host_rdata), .words_flat(words_flat)
  );

  lcdw_sequencer #(.N_COM(N_COM), .CLK_DIV(CLK_DIV)) seq_i (
    .clk(clk), .rst(rst), .run(drive_en), .last_com(last_com),
    .cur_com(cur_com), .neg(neg)
  );

  lcdw_level_map #(.N_SEG(N_SEG), .N_COM(N_COM)) map_i (
    .run(drive_en), .third(cfg_word[0]), .neg(neg), .cur_com(cur_com),
    .last_com(last_com), .words_flat(words_flat), .com_d(com_d), .seg_d(seg_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      com_lvl <= '0;
      seg_lvl <= '0;
    end else begin
      com_lvl <= com_d;
      seg_lvl <= seg_d;
    end
  end
endmodule

// File: rtl/lcdw_chk.sv
module lcdw_chk #(
  parameter int N_SEG  = 32,
  parameter int N_COM  = 4,
  parameter int ADDR_W = 6
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   drive_en,
  input logic [2:0]             cfg_word,
  input logic                   host_re,
  input logic [ADDR_W-1:0]      host_addr,
  input logic [N_COM-1:0]       host_rdata,
  input logic [N_COM*2-1:0]     com_lvl,
  input logic [N_SEG*2-1:0]     seg_lvl
);
  logic [N_COM-1:0] com_ext;
  logic             any_two;
  logic             spare_ok;

  for (genvar k = 0; k < N_COM; k++) begin : g_ext
    assign com_ext[k] = (com_lvl[2*k +: 2] == 2'd0) || (com_lvl[2*k +: 2] == 2'd3);
  end

  always_comb begin
    any_two = 1'b0;
    for (int k = 0; k < N_COM; k++) if (com_lvl[2*k +: 2] == 2'd2) any_two = 1'b1;
    for (int n = 0; n < N_SEG; n++) if (seg_lvl[2*n +: 2] == 2'd2) any_two = 1'b1;
  end

  assign spare_ok = !com_ext[2] && !com_ext[3];

  AST_BLANK_OFF: assert property (@(posedge clk) disable iff (rst)
    !drive_en |=> (com_lvl == '0 && seg_lvl == '0)); // R9

  AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (rst)
    drive_en |=> ($countones(com_ext) <= 1)); // R5

  AST_HALF_NO_TWO: assert property (@(posedge clk) disable iff (rst)
    (drive_en && !cfg_word[0]) |=> !any_two); // R7

  AST_SPARE_COMMONS: assert property (@(posedge clk) disable iff (rst)
    (drive_en && cfg_word[2:1] == 2'b00) |=> spare_ok); // R8

  AST_HIGH_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (host_re && host_addr[ADDR_W-1]) |=> (host_rdata == '0)); // R2

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !host_re |=> $stable(host_rdata)); // R1
endmodule

bind lcd_mux_seq lcdw_chk #(.N_SEG(N_SEG), .N_COM(N_COM), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .drive_en(drive_en), .cfg_word(cfg_word),
  .host_re(host_re), .host_addr(host_addr), .host_rdata(host_rdata),
  .com_lvl(com_lvl), .seg_lvl(seg_lvl)
);

// File: tb/lcd_mux_seq_tb.sv
module lcd_mux_seq_tb_top;
  localparam int NS  = 32;
  localparam int NC  = 4;
  localparam int DIV = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          drive_en = 1'b0;
  logic [2:0]    cfg_word = 3'b101;
  logic          host_we = 1'b0, host_re = 1'b0;
  logic [5:0]    host_addr = '0;
  logic [3:0]    host_wdata = '0;
  logic [3:0]    host_rdata;
  logic [7:0]    com_lvl;
  logic [63:0]   seg_lvl;

  int total = 0, bad = 0;
  logic [3:0] shadow [NS];
  bit done = 0;

  always #2.5 clk = ~clk;

  lcd_mux_seq #(.N_SEG(NS), .N_COM(NC), .ADDR_W(6), .CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .drive_en(drive_en), .cfg_word(cfg_word),
    .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic mem_write(input logic [5:0] a, input logic [3:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    tick();
    host_we = 1'b0;
  endtask

  task automatic mem_read(input logic [5:0] a, output logic [3:0] d);
    host_re = 1'b1; host_addr = a;
    tick();
    host_re = 1'b0;
    d = host_rdata;
  endtask

  function automatic int ncom_of(input logic [2:0] c);
    case (c[2:1]) 2'b00: return 2; 2'b01: return 3; default: return 4; endcase
  endfunction

  function automatic logic [7:0] exp_com(input int act, input bit neg, input bit third, input int ncom);
    logic [7:0] v;
    for (int k = 0; k < NC; k++) begin
      logic [1:0] c;
      if (k < ncom && k == act) c = neg ? 2'd0 : 2'd3;
      else if (third)           c = neg ? 2'd2 : 2'd1;
      else                      c = 2'd1;
      v[2*k +: 2] = c;
    end
    return v;
  endfunction

  function automatic logic [63:0] exp_seg(input int act, input bit neg, input bit third);
    logic [63:0] v;
    for (int n = 0; n < NS; n++) begin
      logic [1:0] c;
      if (shadow[n][act])  c = neg ? 2'd3 : 2'd0;
      else if (third)      c = neg ? 2'd1 : 2'd2;
      else                 c = neg ? 2'd0 : 2'd3;
      v[2*n +: 2] = c;
    end
    return v;
  endfunction

  // R10: reset state
  task automatic t_reset();
    logic [3:0] d;
    check("R10 com after reset", 64'(com_lvl), 64'h0);
    check("R10 seg after reset", seg_lvl, 64'h0);
    check("R10 rdata after reset", 64'(host_rdata), 64'h0);
    mem_read(6'd17, d);
    check("R10 word cleared", 64'(d), 64'h0);
  endtask

  // R1, R2: host port
  task automatic t_memory();
    logic [3:0] d;
    for (int n = 0; n < NS; n++) begin
      shadow[n] = 4'((n * 7 + 3) ^ (n >> 2));
      mem_write(6'(n), shadow[n]);
    end
    mem_read(6'd0, d);  check("R1 read word 0", 64'(d), 64'(shadow[0]));
    mem_read(6'd31, d); check("R1 read word 31", 64'(d), 64'(shadow[31]));
    mem_read(6'd13, d); check("R1 read word 13", 64'(d), 64'(shadow[13]));
    tick(); tick();
    check("R1 rdata held without read", 64'(host_rdata), 64'(shadow[13]));
    mem_write(6'd40, ~shadow[8]);
    mem_read(6'd40, d); check("R2 high address reads zero", 64'(d), 64'h0);
    mem_read(6'd8, d);  check("R2 aliased word untouched", 64'(d), 64'(shadow[8]));
  endtask

  // R3..R8: two full frames for one configuration
  task automatic t_run(input logic [2:0] cfg, input string tag);
    int nc = ncom_of(cfg);
    bit third = cfg[0];
    drive_en = 1'b0; cfg_word = cfg;
    tick();
    drive_en = 1'b1;
    tick();
    for (int p = 0; p < 4 * nc; p++) begin
      int act = p % nc;
      bit neg = ((p / nc) % 2) == 1;
      check({tag, " com start"}, 64'(com_lvl), 64'(exp_com(act, neg, third, nc)));
      check({tag, " seg start"}, seg_lvl, exp_seg(act, neg, third));
      repeat (DIV - 1) tick();
      check({tag, " com end R5"}, 64'(com_lvl), 64'(exp_com(act, neg, third, nc)));
      check({tag, " seg end R3"}, seg_lvl, exp_seg(act, neg, third));
      tick();
    end
    drive_en = 1'b0;
    tick();
  endtask

  // R9: blanking and restart
  task automatic t_blank();
    cfg_word = 3'b101;
    drive_en = 1'b1;
    repeat (3 * DIV + 1) tick();
    drive_en = 1'b0;
    tick();
    check("R9 com blanked", 64'(com_lvl), 64'h0);
    check("R9 seg blanked", seg_lvl, 64'h0);
    repeat (5) tick();
    check("R9 still blank", seg_lvl, 64'h0);
    drive_en = 1'b1;
    tick();
    check("R9 restart com0 positive", 64'(com_lvl), 64'(exp_com(0, 0, 1, 4)));
    check("R9 restart seg", seg_lvl, exp_seg(0, 0, 1));
    drive_en = 1'b0;
    tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    tick();
    t_reset();
    t_memory();
    t_run(3'b101, "R6 R4 four-com third");
    t_run(3'b100, "R7 R4 four-com half");
    t_run(3'b010, "R8 R4 three-com half");
    t_run(3'b001, "R8 R6 two-com third");
    t_run(3'b111, "R4 code11 third");
    t_blank();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule